// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a slave on a two-wire serial bus (one clock line, one open-drain data line) that gives a bus master read and write access to a register file. It runs on a fast system clock and oversamples both bus lines. Each line passes through a synchroniser, and START, STOP and clock edges are then recovered from the synchronised samples. The seven-bit slave address has a fixed upper nibble, a parameter with default `0010`. Its three low bits come from strap inputs, so up to eight of these slaves can share one bus.

In a write transaction, the first byte after the address is a pointer byte. Its low bits select a register and its top bit enables auto-increment. Every byte after that is written to the register file through a single-cycle write strobe. In a read transaction, the slave returns the register selected by the current pointer, most significant bit first. It keeps sending bytes for as long as the master acknowledges them. The pointer and its auto-increment flag persist between transactions, so a master sets the pointer with a short write and then reads after a repeated START.

The register file sits outside the block. The block presents an address, a write strobe and write data, and reads back a combinational read-data port.

Top module: `twi_reg_slave`

## Requirements
- R1: The slave answers an address byte whose upper seven bits equal {ADDR_HI, strap_i[2:1], strap_i[0]} (default ADDR_HI = 4'b0010). It answers by pulling the data line low during the ninth clock. Bit 0 of the address byte selects the direction: 0 for write, 1 for read.
- R2: After an address byte that does not match, the slave never pulls the data line low and issues no register write until the next START.
- R3: In a write, the byte after the address is the pointer byte and is acknowledged. Bits [ADDR_W-1:0] (default bits 6:0) give the register address, and bit 7 is the auto-increment flag.
- R4: Each data byte after the pointer byte is acknowledged. It produces a one-cycle reg_wr_o pulse, with reg_addr_o equal to the current pointer and reg_wdata_o equal to the byte.
- R5: When the auto-increment flag is set, the pointer advances by one, modulo 2^ADDR_W, after each written byte and after each read byte the master acknowledges. When the flag is clear, the pointer does not move, so every access hits the same register.
- R6: In a read, the slave shifts out the register at the current pointer, MSB first. The pointer comes from the last pointer byte received or from the last increment, including one from an earlier transaction.
- R7: After each transmitted byte the slave releases the line for the master's acknowledge. A NACK (line high) ends the read: the slave then stays released until the next START.
- R8: A START or a repeated START, even in the middle of a byte, restarts address reception with an empty bit count. A STOP returns the slave to idle.
- R9: The slave only pulls the data line low or releases it (sda_oe_o = 1 means pull low). It changes sda_oe_o only while the synchronised clock line is low.
- R10: During and right after reset, sda_oe_o = 0, reg_wr_o = 0 and reg_addr_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 3 | Low three bits of the slave address |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_addr_o | output | ADDR_W | Register address (current pointer) |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o |

## Verification
Some properties are checked on every cycle. sda_oe_o only changes while the synchronised clock is low. The data line is never pulled while the slave is idle, ignoring the bus, or waiting for the master's acknowledge. A write strobe lasts one cycle and only occurs while the slave is acknowledging a data byte. Other behaviour only shows up in the bench's transaction sweeps. These cover address matching across every strap value, pointer arithmetic with and without auto-increment (including wrap-around), data that reads back identically after a repeated START, silence after a NACK or a foreign address, and recovery from a START in the middle of a byte.

// File: rtl/twi_pkg.sv
package twi_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_PTR,
      ST_PACK,
      ST_WDAT,
      ST_WACK,
      ST_RDAT,
      ST_RACK,
      ST_IGN
   } twi_st_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
   parameter int              STAGES = 2,
   parameter int              W      = 1,
   parameter logic [W-1:0]    INIT   = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{INIT}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_q,
   input  logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_q;
         sda_d <= sda_q;
      end
   end

   assign scl_rise = scl_q & ~scl_d;
   assign scl_fall = ~scl_q & scl_d;
   // data edges while the clock stays high
   assign start_ev = scl_q & scl_d & sda_d & ~sda_q;
   assign stop_ev  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
   import twi_pkg::*;
#(
   parameter logic [3:0] ADDR_HI = 4'b0010,
   parameter int         ADDR_W  = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          strap,
   input  logic                sda_q,
   input  logic                scl_rise,
   input  logic                scl_fall,
   input  logic                start_ev,
   input  logic                stop_ev,
   input  logic [BYTE_W-1:0]   reg_rdata,
   output logic                sda_drive,
   output logic [ADDR_W-1:0]   reg_addr,
   output logic                reg_wr,
   output logic [BYTE_W-1:0]   reg_wdata,
   output twi_st_e             state
);
   localparam int BITS_W = $clog2(BYTE_W);

   twi_st_e             st;
   logic [BITS_W-1:0]   bit_q;
   logic                full_q;
   logic [BYTE_W-1:0]   sh_q;
   logic [BYTE_W-2:0]   tx_q;
   logic                rw_q, auto_q, nack_q, drive_q, wr_q;
   logic [ADDR_W-1:0]   ptr_q;
   logic [BYTE_W-1:0]   wdata_q;
   logic                addr_hit;

   assign addr_hit = (sh_q[BYTE_W-1:1] == {ADDR_HI, strap});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         bit_q   <= '0;
         full_q  <= 1'b0;
         sh_q    <= '0;
         tx_q    <= '0;
         rw_q    <= 1'b0;
         auto_q  <= 1'b0;
         nack_q  <= 1'b0;
         drive_q <= 1'b0;
         wr_q    <= 1'b0;
         ptr_q   <= '0;
         wdata_q <= '0;
      end else begin
         wr_q <= 1'b0;
         if (start_ev) begin
            st      <= ST_ADDR;
            bit_q   <= '0;
            full_q  <= 1'b0;
            drive_q <= 1'b0;
         end else if (stop_ev) begin
            st      <= ST_IDLE;
            bit_q   <= '0;
            full_q  <= 1'b0;
            drive_q <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_PTR, ST_WDAT: begin
                  if (scl_rise && !full_q) begin
                     sh_q  <= {sh_q[BYTE_W-2:0], sda_q};
                     bit_q <= bit_q + BITS_W'(1);
                     if (bit_q == BITS_W'(BYTE_W - 1)) full_q <= 1'b1;
                  end else if (scl_fall && full_q) begin
                     full_q <= 1'b0;
                     bit_q  <= '0;
                     if (st == ST_ADDR) begin
                        if (addr_hit) begin
                           st      <= ST_AACK;
                           drive_q <= 1'b1;
                           rw_q    <= sh_q[0];
                        end else begin
                           st <= ST_IGN;
                        end
                     end else if (st == ST_PTR) begin
                        st      <= ST_PACK;
                        drive_q <= 1'b1;
                        auto_q  <= sh_q[BYTE_W-1];
                        ptr_q   <= sh_q[ADDR_W-1:0];
                     end else begin
                        st      <= ST_WACK;
                        drive_q <= 1'b1;
                        wr_q    <= 1'b1;
                        wdata_q <= sh_q;
                     end
                  end
               end
               ST_AACK, ST_PACK, ST_WACK: begin
                  if (scl_fall) begin
                     drive_q <= 1'b0;
                     if (st == ST_AACK && rw_q) begin
                        st      <= ST_RDAT;
                        tx_q    <= reg_rdata[BYTE_W-2:0];
                        drive_q <= ~reg_rdata[BYTE_W-1];
                     end else if (st == ST_AACK) begin
                        st <= ST_PTR;
                     end else begin
                        st <= ST_WDAT;
                        if (st == ST_WACK && auto_q) ptr_q <= ptr_q + ADDR_W'(1);
                     end
                  end
               end
               ST_RDAT: begin
                  if (scl_fall) begin
                     if (bit_q == BITS_W'(BYTE_W - 1)) begin
                        bit_q   <= '0;
                        drive_q <= 1'b0;
                        st      <= ST_RACK;
                     end else begin
                        bit_q   <= bit_q + BITS_W'(1);
                        drive_q <= ~tx_q[BYTE_W-2];
                        tx_q    <= {tx_q[BYTE_W-3:0], 1'b0};
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     nack_q <= sda_q;
                     if (!sda_q && auto_q) ptr_q <= ptr_q + ADDR_W'(1);
                  end else if (scl_fall) begin
                     if (nack_q) begin
                        st <= ST_IGN;
                     end else begin
                        st      <= ST_RDAT;
                        tx_q    <= reg_rdata[BYTE_W-2:0];
                        drive_q <= ~reg_rdata[BYTE_W-1];
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_drive = drive_q;
   assign reg_addr  = ptr_q;
   assign reg_wr    = wr_q;
   assign reg_wdata = wdata_q;
   assign state     = st;
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
   import twi_pkg::*;
#(
   parameter logic [3:0] ADDR_HI     = 4'b0010,
   parameter int         ADDR_W      = 7,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        strap_i,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic              reg_wr_o,
   output logic [7:0]        reg_wdata_o,
   input  logic [7:0]        reg_rdata_i
);
   generate
      if (ADDR_W < 2 || ADDR_W > BYTE_W - 1) begin : g_bad_addr_w
         $error("twi_reg_slave: ADDR_W must lie in 2..7");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("twi_reg_slave: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic    scl_q, sda_q;
   logic    scl_rise, scl_fall, start_ev, stop_ev;
   twi_st_e fsm_st;

   twi_sync #(.STAGES(SYNC_STAGES), .W(2), .INIT(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     ({scl_q, sda_q})
   );

   twi_bus_events u_ev (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_q    (scl_q),
      .sda_q    (sda_q),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   twi_slave_fsm #(.ADDR_HI(ADDR_HI), .ADDR_W(ADDR_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap     (strap_i),
      .sda_q     (sda_q),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_ev  (start_ev),
      .stop_ev   (stop_ev),
      .reg_rdata (reg_rdata_i),
      .sda_drive (sda_oe_o),
      .reg_addr  (reg_addr_o),
      .reg_wr    (reg_wr_o),
      .reg_wdata (reg_wdata_o),
      .state     (fsm_st)
   );
endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk
   import twi_pkg::*;
(
   input logic    clk,
   input logic    rst_n,
   input logic    scl_q,
   input logic    sda_oe,
   input logic    reg_wr,
   input twi_st_e st
);
   assert_oe_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl_q));

   assert_wr_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);

   assert_wr_during_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> (st == ST_WACK && sda_oe));

   assert_quiet_when_ignoring_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IGN || st == ST_IDLE) |-> !sda_oe);

   assert_release_for_master_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RACK) |-> !sda_oe);
endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .scl_q  (scl_q),
   .sda_oe (sda_oe_o),
   .reg_wr (reg_wr_o),
   .st     (fsm_st)
);

// File: tb/sim_twi_reg_slave.sv
module sim_twi_reg_slave;
   localparam int AW   = 7;
   localparam int HALF = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n = 1'b0;
   logic [2:0] strap = 3'd0;
   logic       scl_m = 1'b1;
   logic       sda_m_low = 1'b0;
   logic       sda_oe;
   logic [AW-1:0] raddr;
   logic       rwr;
   logic [7:0] rwd, rrd;
   wire        sda_bus = !(sda_m_low || sda_oe);

   logic [7:0] mem   [128];
   logic [7:0] exp_m [128];
   int n_chk = 0, n_bad = 0, r9_bad = 0, hi_cnt = 0;
   logic oe_prev = 1'b0;

   assign rrd = mem[raddr];
   always @(posedge clk) if (rwr) mem[raddr] <= rwd;

   twi_reg_slave u0 (
      .clk(clk), .rst_n(rst_n), .strap_i(strap), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .reg_addr_o(raddr), .reg_wr_o(rwr),
      .reg_wdata_o(rwd), .reg_rdata_i(rrd)
   );

   // R9 monitor: no change of the drive once the clock has been high a while
   always @(negedge clk) begin
      if (scl_m) hi_cnt = hi_cnt + 1; else hi_cnt = 0;
      if (rst_n && sda_oe !== oe_prev && hi_cnt > 4) r9_bad = r9_bad + 1;
      oe_prev = sda_oe;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] ex);
      n_chk++;
      if (act !== ex) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, ex);
      end
   endtask

   task automatic hp();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic start_c();
      sda_m_low = 1'b0; hp();
      scl_m = 1'b1; hp();
      sda_m_low = 1'b1; hp();
      scl_m = 1'b0;
   endtask

   task automatic stop_c();
      repeat (4) @(negedge clk);
      sda_m_low = 1'b1; hp();
      scl_m = 1'b1; hp();
      sda_m_low = 1'b0; hp();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         repeat (4) @(negedge clk);
         sda_m_low = !b[i];
         repeat (HALF - 4) @(negedge clk);
         scl_m = 1'b1; hp();
         scl_m = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      repeat (4) @(negedge clk);
      sda_m_low = 1'b0;
      repeat (HALF - 4) @(negedge clk);
      scl_m = 1'b1; hp();
      ack = !sda_bus;
      scl_m = 1'b0;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      b = 8'h00;
      for (int i = 0; i < 8; i++) begin
         hp();
         scl_m = 1'b1; hp();
         b = {b[6:0], sda_bus};
         scl_m = 1'b0;
      end
      repeat (4) @(negedge clk);
      sda_m_low = give_ack;
      repeat (HALF - 4) @(negedge clk);
      scl_m = 1'b1; hp();
      scl_m = 1'b0;
      repeat (4) @(negedge clk);
      sda_m_low = 1'b0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic ack;
      logic [7:0] b, d0, d1;
      logic [6:0] base;
      logic [7:0] mis;
      for (int i = 0; i < 128; i++) begin
         mem[i]   = 8'(i * 37 + 5);
         exp_m[i] = 8'(i * 37 + 5);
      end
      repeat (5) @(negedge clk);
      chk("R10 oe in reset", 32'(sda_oe), 0);
      chk("R10 wr in reset", 32'(rwr), 0);
      chk("R10 addr in reset", 32'(raddr), 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk("R10 oe after reset", 32'(sda_oe), 0);

      for (int s = 0; s < 8; s++) begin
         strap = 3'(s);
         base  = 7'(s * 16);
         d0    = 8'(s * 17 + 1);
         d1    = ~d0;
         repeat (4) @(negedge clk);
         // write two bytes with auto-increment
         start_c();
         send_byte({4'b0010, 3'(s), 1'b0}, ack); chk("R1 address ack", 32'(ack), 1);
         send_byte({1'b1, base}, ack);           chk("R3 pointer ack", 32'(ack), 1);
         send_byte(d0, ack);                     chk("R4 data ack 0", 32'(ack), 1);
         send_byte(d1, ack);                     chk("R4 data ack 1", 32'(ack), 1);
         stop_c();
         exp_m[base] = d0;
         exp_m[7'(base + 7'd1)] = d1;
         // foreign address: nothing answers, nothing written
         mis = (s % 2 == 1) ? {4'b0011, 3'(s), 1'b0} : {4'b0010, 3'(s) ^ 3'b001, 1'b0};
         start_c();
         send_byte(mis, ack);                    chk("R2 foreign address nack", 32'(ack), 0);
         send_byte({1'b1, base}, ack);           chk("R2 silent after mismatch", 32'(ack), 0);
         send_byte(8'hEE, ack);
         stop_c();
         // read back after a repeated START
         start_c();
         send_byte({4'b0010, 3'(s), 1'b0}, ack);
         send_byte({1'b1, base}, ack);
         start_c();
         send_byte({4'b0010, 3'(s), 1'b1}, ack); chk("R8 repeated start ack", 32'(ack), 1);
         recv_byte(1'b1, b);                     chk("R6 read first", 32'(b), 32'(exp_m[base]));
         recv_byte(1'b0, b);                     chk("R7 read burst second", 32'(b), 32'(exp_m[7'(base + 7'd1)]));
         stop_c();
      end

      // R5: no auto-increment, three writes land on one register
      strap = 3'd5;
      start_c();
      send_byte(8'h2A, ack);
      send_byte(8'h10, ack);
      send_byte(8'hA1, ack);
      send_byte(8'hA2, ack);
      send_byte(8'hA3, ack);
      stop_c();
      exp_m[7'h10] = 8'hA3;
      start_c();
      send_byte(8'h2A, ack);
      send_byte(8'h10, ack);
      start_c();
      send_byte(8'h2B, ack);
      recv_byte(1'b1, b); chk("R5 fixed pointer read 0", 32'(b), 32'(exp_m[7'h10]));
      recv_byte(1'b0, b); chk("R5 fixed pointer read 1", 32'(b), 32'(exp_m[7'h10]));
      stop_c();
      start_c();
      send_byte(8'h2A, ack);
      send_byte(8'h91, ack);
      start_c();
      send_byte(8'h2B, ack);
      recv_byte(1'b0, b); chk("R5 neighbour untouched", 32'(b), 32'(exp_m[7'h11]));
      stop_c();

      // R5: pointer wraps from 127 to 0
      start_c();
      send_byte(8'h2A, ack);
      send_byte(8'hFF, ack);
      send_byte(8'hB1, ack);
      send_byte(8'hB2, ack);
      stop_c();
      exp_m[127] = 8'hB1;
      exp_m[0]   = 8'hB2;
      start_c();
      send_byte(8'h2A, ack);
      send_byte(8'hFF, ack);
      start_c();
      send_byte(8'h2B, ack);
      recv_byte(1'b1, b); chk("R5 wrap read top", 32'(b), 32'(exp_m[127]));
      recv_byte(1'b0, b); chk("R5 wrap read zero", 32'(b), 32'(exp_m[0]));
      // R7: after NACK the slave stays silent
      send_byte(8'h00, ack); chk("R7 silent after nack", 32'(ack), 0);
      stop_c();

      // R8: START in the middle of a byte restarts address reception
      start_c();
      send_bits(8'h2A, 3);
      start_c();
      send_byte(8'h2A, ack); chk("R8 mid-byte restart ack", 32'(ack), 1);
      send_byte(8'h85, ack);
      send_byte(8'h5A, ack); chk("R4 data after restart", 32'(ack), 1);
      stop_c();
      exp_m[5] = 8'h5A;
      // R6: read from retained pointer (now 6) without a pointer byte
      start_c();
      send_byte(8'h2B, ack);
      recv_byte(1'b0, b); chk("R6 retained pointer read", 32'(b), 32'(exp_m[6]));
      stop_c();
      chk("R4 stored value", 32'(mem[5]), 32'h5A);

      chk("R9 drive changes only with clock low", r9_bad, 0);
      summary();
      $finish;
   end
endmodule